// File: doc/BRIEF.md
# Buffered Asynchronous Serial Receiver

This block receives asynchronous serial characters of eight or nine data bits on a line sampled by a sixteen-times oversample tick. A falling edge seen on a tick starts a candidate frame. The candidate is kept only if a majority vote of three samples taken around the middle of the start bit reads low. Each data bit, sent least significant bit first, is decided by the same three-sample vote around its centre. The stop bit is judged the same way, and a low stop bit marks a framing error that is stored with that character.

Finished characters go into a two-entry queue and are read back oldest first. The head entry is always shown on the read outputs, and a read strobe removes it. In nine-bit mode an address filter can discard every character whose ninth bit is clear, so that only address characters reach the queue. A character that completes while both entries are occupied, with no read in the same cycle, is lost and sets the overrun flag. While the overrun flag is set, the receiver takes in no further frames. Dropping the enable clears the flag and keeps the queue contents.

Top module: `async_rx_buf`

## Requirements
- R1: With `nine_bit` low, a frame carries eight data bits, least significant bit first, and `rd_bit9` reads 0 for that character.
- R2: With `nine_bit` high, a frame carries nine data bits, least significant bit first. The ninth received bit appears on `rd_bit9` and the first eight appear on `rd_data`.
- R3: A low level that is not still low by majority vote at oversample ticks 7, 8 and 9 after the tick on which it was first seen is dropped as a false start, and no character results.
- R4: Each data bit takes the majority of three samples at ticks 7, 8 and 9 of its bit window, so an opposite level at only the central sample does not change the bit.
- R5: The queue holds up to two characters and presents them oldest first. `data_avail` is high while the queue holds at least one character. A high `rd_stb` removes the head entry, and a strobe on an empty queue changes nothing.
- R6: With `nine_bit` and `addr_filt` both high, a character whose ninth bit is 0 is discarded and a character whose ninth bit is 1 is stored. With `nine_bit` low, `addr_filt` has no effect.
- R7: A stop bit judged low sets `rd_ferr` for that character only. A following good character reads `rd_ferr` 0.
- R8: A character that completes while two entries are held and `rd_stb` is low is discarded and sets `overrun`. The two stored characters remain unchanged.
- R9: While `overrun` is high, no new character is stored. Driving `rx_en` low clears `overrun`, keeps the queue, and reception works again once `rx_en` returns high.
- R10: If a character completes in the same cycle that `rd_stb` removes the head of a full queue, the new character is stored and `overrun` stays low.
- R11: After reset, `data_avail` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low clears overrun and idles the frame logic |
| nine_bit | input | 1 | 1 selects nine data bits, 0 selects eight |
| addr_filt | input | 1 | In nine-bit mode, store only characters whose ninth bit is 1 |
| os_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rx_line | input | 1 | Serial line, idle high |
| rd_stb | input | 1 | Removes the head entry of the queue |
| rd_data | output | 8 | Data bits of the head entry |
| rd_bit9 | output | 1 | Ninth bit of the head entry |
| rd_ferr | output | 1 | Framing error of the head entry |
| data_avail | output | 1 | Queue holds at least one character |
| overrun | output | 1 | A character was lost to a full queue |

## Verification
The case that needs care is a stop-bit decision landing in the same clock cycle as a read strobe while the queue is full. The queue must then take a write and a removal together instead of reporting an overrun. The bench fills both entries and sends a third character. It raises `rd_stb` for one cycle, timed to follow the ninth oversample tick of the stop bit, which is the cycle the finished character reaches the queue. It then expects `overrun` low and reads back the second and third characters in that order.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_START,
    FS_DATA,
    FS_STOP
  } frame_st_t;

  typedef struct packed {
    logic       ferr;
    logic       b9;
    logic [7:0] data;
  } rx_char_t;

  // majority of three line samples
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // index of the final data bit in a frame
  function automatic logic [3:0] last_bit_idx(input logic nine);
    return nine ? 4'd8 : 4'd7;
  endfunction

  // address filter: in nine-bit mode with filtering on, keep only b9 = 1
  function automatic logic keep_char(input logic nine, input logic filt, input logic b9);
    return !(nine && filt) || b9;
  endfunction

  // data byte out of the shift register, which fills from the top
  function automatic logic [7:0] pick_data(input logic nine, input logic [8:0] sh);
    return nine ? sh[7:0] : sh[8:1];
  endfunction

endpackage

// File: rtl/rxq_frame.sv
// Frame recovery: start validation, three-sample voting, LSB-first shift.
// OSR must be a power of two so the phase counter wraps once per bit.
module rxq_frame
  import rxq_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run,
  input  logic     nine_bit,
  input  logic     os_tick,
  input  logic     rx_line,
  output logic     char_done,
  output rx_char_t char_out
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] PH_A   = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] PH_B   = CW'(OSR/2);
  localparam logic [CW-1:0] PH_C   = CW'(OSR/2 + 1);
  localparam logic [CW-1:0] PH_ONE = CW'(1);

  logic          line_m, line_s;
  frame_st_t     st;
  logic [CW-1:0] ph;
  logic [CW-1:0] ph_nxt;
  logic          s_a, s_b;
  logic [3:0]    bidx;
  logic [8:0]    sh;
  logic          vote;
  logic          decide;

  // two-stage synchronizer, idle-high reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_m <= 1'b1;
      line_s <= 1'b1;
    end else begin
      line_m <= rx_line;
      line_s <= line_m;
    end
  end

  assign ph_nxt = ph + 1'b1;
  assign vote   = maj3(s_a, s_b, line_s);
  assign decide = os_tick && (st != FS_IDLE) && (ph_nxt == PH_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= FS_IDLE;
      ph        <= '0;
      s_a       <= 1'b1;
      s_b       <= 1'b1;
      bidx      <= '0;
      sh        <= '0;
      char_done <= 1'b0;
      char_out  <= '0;
    end else begin
      char_done <= 1'b0;
      if (!run) begin
        st <= FS_IDLE;
        ph <= '0;
      end else if (os_tick) begin
        if (st == FS_IDLE) begin
          if (!line_s) begin
            st <= FS_START;
            ph <= PH_ONE;
          end
        end else begin
          ph <= ph_nxt;
          if (ph_nxt == PH_A) s_a <= line_s;
          if (ph_nxt == PH_B) s_b <= line_s;
          if (decide) begin
            unique case (st)
              FS_START: begin
                if (!vote) begin
                  st   <= FS_DATA;
                  bidx <= '0;
                end else begin
                  st <= FS_IDLE;
                end
              end
              FS_DATA: begin
                sh <= {vote, sh[8:1]};
                if (bidx == last_bit_idx(nine_bit)) st <= FS_STOP;
                else bidx <= bidx + 1'b1;
              end
              FS_STOP: begin
                char_done     <= 1'b1;
                char_out.data <= pick_data(nine_bit, sh);
                char_out.b9   <= nine_bit ? sh[8] : 1'b0;
                char_out.ferr <= !vote;
                st            <= FS_IDLE;
              end
              default: st <= FS_IDLE;
            endcase
          end
        end
      end
    end
  end

endmodule

// File: rtl/rxq_buf.sv
// Small in-order character queue; a write into a full queue is accepted
// only when the head is removed in the same cycle.
module rxq_buf
  import rxq_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  rx_char_t                   wr_char,
  input  logic                       pop,
  output logic                       stored,
  output logic                       ovf,
  output rx_char_t                   head,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int NW = $clog2(DEPTH + 1);
  localparam logic [NW-1:0] FULL_CNT = NW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  rx_char_t        mem [DEPTH];
  logic [PW-1:0]   wptr, rptr;
  logic            do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign do_pop = pop && (cnt != '0);
  assign stored = push && ((cnt != FULL_CNT) || do_pop);
  assign ovf    = push && !stored;
  assign head   = mem[rptr];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[g] <= '0;
        else if (stored && (wptr == PW'(g))) mem[g] <= wr_char;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (stored) wptr <= step(wptr);
      if (do_pop) rptr <= step(rptr);
      case ({stored, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/async_rx_buf.sv
module async_rx_buf
  import rxq_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       nine_bit,
  input  logic       addr_filt,
  input  logic       os_tick,
  input  logic       rx_line,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  output logic       rd_bit9,
  output logic       rd_ferr,
  output logic       data_avail,
  output logic       overrun
);

  localparam int CNTW = $clog2(DEPTH + 1);

  // named internal events
  logic            run;
  logic            char_done;
  rx_char_t        char_q;
  logic            char_b9;
  logic            push_req;
  logic            store;
  logic            ovf_evt;
  rx_char_t        head;
  logic [CNTW-1:0] buf_cnt;

  assign run      = rx_en && !overrun;
  assign char_b9  = char_q.b9;
  assign push_req = char_done && keep_char(nine_bit, addr_filt, char_b9);

  rxq_frame #(.OSR(OSR)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .nine_bit (nine_bit),
    .os_tick  (os_tick),
    .rx_line  (rx_line),
    .char_done(char_done),
    .char_out (char_q)
  );

  rxq_buf #(.DEPTH(DEPTH)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push_req),
    .wr_char(char_q),
    .pop    (rd_stb),
    .stored (store),
    .ovf    (ovf_evt),
    .head   (head),
    .cnt    (buf_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (!rx_en)  overrun <= 1'b0;
    else if (ovf_evt) overrun <= 1'b1;
  end

  assign rd_data    = head.data;
  assign rd_bit9    = head.b9;
  assign rd_ferr    = head.ferr;
  assign data_avail = (buf_cnt != '0);

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DEPTH = 2,
  parameter int CNTW  = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_en,
  input logic            nine_bit,
  input logic            addr_filt,
  input logic            rd_stb,
  input logic            char_done,
  input logic            char_b9,
  input logic            push_req,
  input logic            store,
  input logic            ovf_evt,
  input logic            data_avail,
  input logic            overrun,
  input logic [CNTW-1:0] buf_cnt
);

  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  p_ovf_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && rx_en) |=> overrun);

  p_ovf_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> (buf_cnt == FULL_CNT) && !rd_stb);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !char_done);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun);

  p_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && nine_bit && addr_filt && !char_b9) |-> !store);

  p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && rd_stb && data_avail) |-> (store && !ovf_evt));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_cnt <= FULL_CNT);

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !data_avail && !store) |=> !data_avail);

endmodule

bind async_rx_buf rxq_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .nine_bit  (nine_bit),
  .addr_filt (addr_filt),
  .rd_stb    (rd_stb),
  .char_done (char_done),
  .char_b9   (char_b9),
  .push_req  (push_req),
  .store     (store),
  .ovf_evt   (ovf_evt),
  .data_avail(data_avail),
  .overrun   (overrun),
  .buf_cnt   (buf_cnt)
);

// File: tb/async_rx_buf_test.sv
module async_rx_buf_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       nine_bit = 1'b0;
  logic       addr_filt = 1'b0;
  logic       os_tick = 1'b0;
  logic       rx_line = 1'b1;
  logic       rd_stb = 1'b0;
  logic [7:0] rd_data;
  logic       rd_bit9;
  logic       rd_ferr;
  logic       data_avail;
  logic       overrun;
  logic [1:0] tdiv = 2'd0;
  int         checks = 0;
  int         fails = 0;

  async_rx_buf uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .nine_bit(nine_bit),
    .addr_filt(addr_filt), .os_tick(os_tick), .rx_line(rx_line),
    .rd_stb(rd_stb), .rd_data(rd_data), .rd_bit9(rd_bit9),
    .rd_ferr(rd_ferr), .data_avail(data_avail), .overrun(overrun)
  );

  always #5 clk = ~clk;

  // oversample tick: one clock in four, changed away from the active edge
  always @(negedge clk) begin
    tdiv    <= tdiv + 2'd1;
    os_tick <= (tdiv == 2'd3);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (!os_tick);
  endtask

  // one frame: start, nbits data (LSB first), stop level stop_v
  task automatic send(input logic [8:0] val, input int nbits, input logic stop_v,
                      input int glitch_bit, input bit pop_at_stop);
    wait_tick();
    @(negedge clk) rx_line = 1'b0;
    repeat (16) wait_tick();
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk) rx_line = val[i];
      for (int t = 1; t <= 16; t++) begin
        wait_tick();
        if (i == glitch_bit && t == 7) @(negedge clk) rx_line = ~val[i];
        if (i == glitch_bit && t == 8) @(negedge clk) rx_line = val[i];
      end
    end
    @(negedge clk) rx_line = stop_v;
    for (int t = 1; t <= 16; t++) begin
      wait_tick();
      if (pop_at_stop && t == 9) begin
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
      end
    end
    @(negedge clk) rx_line = 1'b1;
    repeat (20) wait_tick();
  endtask

  task automatic read_expect(input string req, input logic [7:0] d, input logic b9, input logic fe);
    @(negedge clk);
    check({req, " avail"}, 32'(data_avail), 32'd1);
    check({req, " data"},  32'(rd_data), 32'(d));
    check({req, " bit9"},  32'(rd_bit9), 32'(b9));
    check({req, " ferr"},  32'(rd_ferr), 32'(fe));
    rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
  endtask

  task automatic expect_empty(input string req);
    @(negedge clk);
    check({req, " empty"}, 32'(data_avail), 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 avail", 32'(data_avail), 32'd0);
    check("R11 overrun", 32'(overrun), 32'd0);
  endtask

  task automatic t_eight();
    nine_bit = 1'b0;
    send(9'h0A5, 8, 1'b1, -1, 1'b0);
    read_expect("R1", 8'hA5, 1'b0, 1'b0);
    send(9'h03C, 8, 1'b1, -1, 1'b0);
    read_expect("R1", 8'h3C, 1'b0, 1'b0);
    expect_empty("R1");
  endtask

  task automatic t_nine();
    nine_bit = 1'b1;
    send(9'h1C3, 9, 1'b1, -1, 1'b0);
    read_expect("R2", 8'hC3, 1'b1, 1'b0);
    send(9'h081, 9, 1'b1, -1, 1'b0);
    read_expect("R2", 8'h81, 1'b0, 1'b0);
    nine_bit = 1'b0;
  endtask

  task automatic t_false_start();
    wait_tick();
    @(negedge clk) rx_line = 1'b0;
    repeat (3) wait_tick();
    @(negedge clk) rx_line = 1'b1;
    repeat (40) wait_tick();
    expect_empty("R3 glitch");
    send(9'h05A, 8, 1'b1, -1, 1'b0);
    read_expect("R3 recover", 8'h5A, 1'b0, 1'b0);
  endtask

  task automatic t_vote();
    send(9'h000, 8, 1'b1, 3, 1'b0);
    read_expect("R4 low", 8'h00, 1'b0, 1'b0);
    send(9'h0FF, 8, 1'b1, 6, 1'b0);
    read_expect("R4 high", 8'hFF, 1'b0, 1'b0);
  endtask

  task automatic t_order();
    send(9'h011, 8, 1'b1, -1, 1'b0);
    send(9'h022, 8, 1'b1, -1, 1'b0);
    @(negedge clk) check("R5 no overrun", 32'(overrun), 32'd0);
    read_expect("R5 first", 8'h11, 1'b0, 1'b0);
    read_expect("R5 second", 8'h22, 1'b0, 1'b0);
    expect_empty("R5");
    @(negedge clk) rd_stb = 1'b1;
    @(negedge clk) rd_stb = 1'b0;
    expect_empty("R5 idle read");
    send(9'h033, 8, 1'b1, -1, 1'b0);
    read_expect("R5 after idle read", 8'h33, 1'b0, 1'b0);
    expect_empty("R5");
  endtask

  task automatic t_filter();
    nine_bit = 1'b1;
    addr_filt = 1'b1;
    send(9'h044, 9, 1'b1, -1, 1'b0);
    expect_empty("R6 drop");
    send(9'h155, 9, 1'b1, -1, 1'b0);
    read_expect("R6 keep", 8'h55, 1'b1, 1'b0);
    expect_empty("R6");
    nine_bit = 1'b0;
    send(9'h066, 8, 1'b1, -1, 1'b0);
    read_expect("R6 eight-bit", 8'h66, 1'b0, 1'b0);
    addr_filt = 1'b0;
  endtask

  task automatic t_frame();
    send(9'h0C8, 8, 1'b0, -1, 1'b0);
    send(9'h037, 8, 1'b1, -1, 1'b0);
    read_expect("R7 bad stop", 8'hC8, 1'b0, 1'b1);
    read_expect("R7 good stop", 8'h37, 1'b0, 1'b0);
  endtask

  task automatic t_overrun();
    send(9'h0A1, 8, 1'b1, -1, 1'b0);
    send(9'h0A2, 8, 1'b1, -1, 1'b0);
    send(9'h0A3, 8, 1'b1, -1, 1'b0);
    @(negedge clk) check("R8 overrun", 32'(overrun), 32'd1);
    read_expect("R8 kept first", 8'hA1, 1'b0, 1'b0);
    read_expect("R8 kept second", 8'hA2, 1'b0, 1'b0);
    expect_empty("R8 lost third");
    send(9'h0A4, 8, 1'b1, -1, 1'b0);
    expect_empty("R9 halted");
    @(negedge clk) check("R9 still set", 32'(overrun), 32'd1);
    send(9'h0B1, 8, 1'b1, -1, 1'b0);
    send(9'h0B2, 8, 1'b1, -1, 1'b0);
    expect_empty("R9 halted");
    // refill is not possible while halted; clear with the enable
    @(negedge clk) rx_en = 1'b0;
    @(negedge clk) rx_en = 1'b1;
    @(negedge clk) check("R9 cleared", 32'(overrun), 32'd0);
    send(9'h0B3, 8, 1'b1, -1, 1'b0);
    send(9'h0B4, 8, 1'b1, -1, 1'b0);
    send(9'h0B5, 8, 1'b1, -1, 1'b0);
    @(negedge clk) check("R8 set again", 32'(overrun), 32'd1);
    @(negedge clk) rx_en = 1'b0;
    @(negedge clk) rx_en = 1'b1;
    @(negedge clk) check("R9 cleared again", 32'(overrun), 32'd0);
    read_expect("R9 queue kept", 8'hB3, 1'b0, 1'b0);
    read_expect("R9 queue kept", 8'hB4, 1'b0, 1'b0);
    expect_empty("R9");
    send(9'h0B6, 8, 1'b1, -1, 1'b0);
    read_expect("R9 resumed", 8'hB6, 1'b0, 1'b0);
  endtask

  task automatic t_collide();
    send(9'h0D1, 8, 1'b1, -1, 1'b0);
    send(9'h0D2, 8, 1'b1, -1, 1'b0);
    send(9'h0D3, 8, 1'b1, -1, 1'b1);
    @(negedge clk) check("R10 no overrun", 32'(overrun), 32'd0);
    read_expect("R10 second", 8'hD2, 1'b0, 1'b0);
    read_expect("R10 third", 8'hD3, 1'b0, 1'b0);
    expect_empty("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    @(negedge clk) rx_en = 1'b1;
    repeat (8) @(negedge clk);
    t_eight();
    t_nine();
    t_false_start();
    t_vote();
    t_order();
    t_filter();
    t_frame();
    t_overrun();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule